// File: doc/BRIEF.md
# SPI FIFO, Interrupt and DMA Request Unit

This block holds the two word queues of an SPI controller. Words written by software wait in the transmit queue until the serial engine takes them. Words that the engine captures wait in the receive queue until software reads them. Around the two queues, the block derives level-based interrupt conditions and DMA request lines from programmable thresholds. It also keeps sticky error flags for overflow, underflow and a chip-select-inactive event. All of these feed one masked, combined interrupt line and a six-bit status word.

A three-state run controller follows the controller enable. It has the states `ST_IDLE` (controller disabled), `ST_RUN` (controller enabled) and `ST_FLUSH` (a one-cycle purge after the enable drops). The transitions are:
- `ST_IDLE` to `ST_RUN` when the enable rises.
- `ST_RUN` to `ST_FLUSH` when the enable falls.
- `ST_FLUSH` to `ST_RUN` if the enable is back high, and to `ST_IDLE` otherwise.

The four threshold registers only take a new value while the enable is low. This means a level comparison can never shift under a transfer in progress.

Queue depth and word width are parameters. The queue is 32 or 64 words deep in use, and each word is up to 16 bits wide.

Top module: `spi_fifo_event_unit`

## Requirements
- R1: Each queue returns words in the order they were pushed, and its level output equals the number of words held; the head word is presented combinationally on the pop-side data port.
- R2: A push to a full queue discards the word, leaves the contents unchanged and sets a sticky flag: interrupt bit 1 for the transmit queue, bit 3 for the receive queue.
- R3: A software pop from an empty receive queue returns zero and sets sticky interrupt bit 2.
- R4: Raw interrupt bit 0 is high while transmit level <= transmit threshold; bit 4 is high while receive level >= receive threshold + 1; bit 5 is always 0.
- R5: A clear strobe with clear word bit 0 clears all sticky flags (bits 1, 2, 3, 6); clear bit 1 clears bit 2, clear bit 2 clears bit 3, clear bit 3 clears bit 1; an event in the same cycle as its clear leaves the flag set.
- R6: A pulse on the chip-select-inactive input sets sticky interrupt bit 6 from the next cycle.
- R7: Each masked interrupt bit equals the raw bit ANDed with the mask bit, and the interrupt line is the OR of the masked bits.
- R8: Status bit 0 is engine busy, bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full, bit 5 slave transmit busy.
- R9: With DMA enable bit 1 set, the transmit request is high while transmit level <= its DMA level; with DMA enable bit 0 set, the receive request is high while receive level > its DMA level; a cleared enable bit forces its request low.
- R10: A threshold write strobe is ignored while the controller enable is high and takes effect in the next cycle while it is low.
- R11: When the enable is seen low in `ST_RUN`, the unit spends one cycle in `ST_FLUSH`, keeping the levels for that cycle, and both queues are empty after it; a push made during the flush cycle is dropped.
- R12: After reset both queues are empty, the thresholds and sticky flags are zero and the state is `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_en | input | 1 | Controller enable |
| eng_busy | input | 1 | Serial engine busy, shown as status bit 0 |
| eng_slv_tx_busy | input | 1 | Slave-mode transmit busy, shown as status bit 5 |
| sw_tx_push | input | 1 | Software write into the transmit queue |
| sw_tx_data | input | WIDTH | Word written by software |
| sw_rx_pop | input | 1 | Software read from the receive queue |
| sw_rx_data | output | WIDTH | Head of the receive queue, zero when empty |
| eng_tx_pop | input | 1 | Engine takes a transmit word |
| eng_tx_data | output | WIDTH | Head of the transmit queue, zero when empty |
| eng_rx_push | input | 1 | Engine stores a received word |
| eng_rx_data | input | WIDTH | Word stored by the engine |
| thr_wr | input | 1 | Threshold write strobe |
| tx_irq_thr | input | AW | Transmit interrupt threshold |
| rx_irq_thr | input | AW | Receive interrupt threshold |
| tx_dma_lvl | input | AW | Transmit DMA level |
| rx_dma_lvl | input | AW | Receive DMA level |
| dma_en | input | 2 | Bit 0 receive, bit 1 transmit request enable |
| irq_mask | input | 7 | Interrupt mask |
| clr_wr | input | 1 | Clear strobe |
| clr_word | input | 4 | Clear word |
| cs_inactive | input | 1 | Chip-select-inactive event pulse |
| tx_level | output | LW | Transmit queue level |
| rx_level | output | LW | Receive queue level |
| raw_irq | output | 7 | Raw interrupt vector |
| msk_irq | output | 7 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt line |
| status | output | 6 | Status word |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench builds the unit with a depth of 8 and a word width of 8. At that size it can fill and drain both queues once for every threshold value 0 to 7. At every level from empty to full it compares both level interrupts and both DMA requests with the arithmetic rule. It also walks all 128 mask patterns against a known raw vector, and all four combinations of the engine status inputs. Over one small configuration, this covers every full/empty boundary, every clear bit, the same-cycle set-versus-clear case and the flush cycle.

// File: rtl/spi_fbu_pkg.sv
package spi_fbu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } run_state_t;

    localparam int IRQ_W       = 7;
    localparam int ST_W        = 6;
    localparam int BIT_TX_LOW  = 0;
    localparam int BIT_TX_OVF  = 1;
    localparam int BIT_RX_UDF  = 2;
    localparam int BIT_RX_OVF  = 3;
    localparam int BIT_RX_HIGH = 4;
    localparam int BIT_CS_OFF  = 6;
endpackage

// File: rtl/fbu_word_fifo.sv
module fbu_word_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty,
    output logic             ovf,
    output logic             udf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [LW-1:0]    cnt;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign ovf     = push && full;
    assign udf     = pop && empty;
    assign level   = cnt;
    assign dout    = empty ? '0 : mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= ptr_next(wp);
            if (do_pop)  rp <= ptr_next(rp);
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LW'(DEPTH));
    p_full_push_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == LW'(DEPTH)));
    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/fbu_events.sv
module fbu_events
    import spi_fbu_pkg::*;
#(
    parameter int LW = 6,
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    tx_lvl,
    input  logic [LW-1:0]    rx_lvl,
    input  logic [AW-1:0]    tx_thr,
    input  logic [AW-1:0]    rx_thr,
    input  logic [AW-1:0]    tx_dlvl,
    input  logic [AW-1:0]    rx_dlvl,
    input  logic [1:0]       dma_en,
    input  logic [IRQ_W-1:0] mask,
    input  logic             clr_wr,
    input  logic [3:0]       clr_word,
    input  logic             tx_ovf_ev,
    input  logic             rx_ovf_ev,
    input  logic             rx_udf_ev,
    input  logic             cs_ev,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] msk,
    output logic             irq,
    output logic             dma_tx_req,
    output logic             dma_rx_req
);
    logic st_txo, st_rxo, st_rxu, st_cs;
    logic c_all, c_txo, c_rxo, c_rxu;

    assign c_all = clr_wr && clr_word[0];
    assign c_rxu = c_all || (clr_wr && clr_word[1]);
    assign c_rxo = c_all || (clr_wr && clr_word[2]);
    assign c_txo = c_all || (clr_wr && clr_word[3]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_txo <= 1'b0;
            st_rxo <= 1'b0;
            st_rxu <= 1'b0;
            st_cs  <= 1'b0;
        end else begin
            st_txo <= tx_ovf_ev || (st_txo && !c_txo);
            st_rxo <= rx_ovf_ev || (st_rxo && !c_rxo);
            st_rxu <= rx_udf_ev || (st_rxu && !c_rxu);
            st_cs  <= cs_ev     || (st_cs  && !c_all);
        end
    end

    always_comb begin
        raw              = '0;
        raw[BIT_TX_LOW]  = ({1'b0, tx_lvl} <= (LW + 1)'(tx_thr));
        raw[BIT_TX_OVF]  = st_txo;
        raw[BIT_RX_UDF]  = st_rxu;
        raw[BIT_RX_OVF]  = st_rxo;
        raw[BIT_RX_HIGH] = ({1'b0, rx_lvl} >= (LW + 1)'(rx_thr) + 1'b1);
        raw[BIT_CS_OFF]  = st_cs;
        msk              = raw & mask;
        irq              = |msk;
        dma_tx_req       = dma_en[1] && ({1'b0, tx_lvl} <= (LW + 1)'(tx_dlvl));
        dma_rx_req       = dma_en[0] && ({1'b0, rx_lvl} > (LW + 1)'(rx_dlvl));
    end

    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_txo && !(clr_wr && (clr_word[0] || clr_word[3]))) |=> st_txo);
    p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_udf_ev |=> raw[BIT_RX_UDF]);
    p_cs_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_ev |=> raw[BIT_CS_OFF]);
    p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & mask) == '0) |-> !irq);
    p_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en[1] |-> !dma_tx_req);
endmodule

// File: rtl/spi_fifo_event_unit.sv
module spi_fifo_event_unit
    import spi_fbu_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             eng_busy,
    input  logic             eng_slv_tx_busy,
    input  logic             sw_tx_push,
    input  logic [WIDTH-1:0] sw_tx_data,
    input  logic             sw_rx_pop,
    output logic [WIDTH-1:0] sw_rx_data,
    input  logic             eng_tx_pop,
    output logic [WIDTH-1:0] eng_tx_data,
    input  logic             eng_rx_push,
    input  logic [WIDTH-1:0] eng_rx_data,
    input  logic             thr_wr,
    input  logic [AW-1:0]    tx_irq_thr,
    input  logic [AW-1:0]    rx_irq_thr,
    input  logic [AW-1:0]    tx_dma_lvl,
    input  logic [AW-1:0]    rx_dma_lvl,
    input  logic [1:0]       dma_en,
    input  logic [6:0]       irq_mask,
    input  logic             clr_wr,
    input  logic [3:0]       clr_word,
    input  logic             cs_inactive,
    output logic [LW-1:0]    tx_level,
    output logic [LW-1:0]    rx_level,
    output logic [6:0]       raw_irq,
    output logic [6:0]       msk_irq,
    output logic             irq,
    output logic [5:0]       status,
    output logic             dma_tx_req,
    output logic             dma_rx_req
);
    run_state_t state, state_nx;
    logic       flush;
    logic [AW-1:0] tx_thr_q, rx_thr_q, tx_dl_q, rx_dl_q;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_ovf, tx_udf_unused, rx_ovf, rx_udf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (ctl_en)  state_nx = ST_RUN;
            ST_RUN:   if (!ctl_en) state_nx = ST_FLUSH;
            ST_FLUSH: state_nx = ctl_en ? ST_RUN : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        flush  = (state == ST_FLUSH);
        status = {eng_slv_tx_busy, rx_full, rx_empty, tx_empty, tx_full, eng_busy};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= '0;
            tx_dl_q  <= '0;
            rx_dl_q  <= '0;
        end else if (thr_wr && !ctl_en) begin
            tx_thr_q <= tx_irq_thr;
            rx_thr_q <= rx_irq_thr;
            tx_dl_q  <= tx_dma_lvl;
            rx_dl_q  <= rx_dma_lvl;
        end
    end

    fbu_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LW(LW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(sw_tx_push), .din(sw_tx_data), .pop(eng_tx_pop),
        .dout(eng_tx_data), .level(tx_level), .full(tx_full), .empty(tx_empty),
        .ovf(tx_ovf), .udf(tx_udf_unused)
    );

    fbu_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LW(LW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(eng_rx_push), .din(eng_rx_data), .pop(sw_rx_pop),
        .dout(sw_rx_data), .level(rx_level), .full(rx_full), .empty(rx_empty),
        .ovf(rx_ovf), .udf(rx_udf)
    );

    fbu_events #(.LW(LW), .AW(AW)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .tx_lvl(tx_level), .rx_lvl(rx_level),
        .tx_thr(tx_thr_q), .rx_thr(rx_thr_q), .tx_dlvl(tx_dl_q), .rx_dlvl(rx_dl_q),
        .dma_en(dma_en), .mask(irq_mask), .clr_wr(clr_wr), .clr_word(clr_word),
        .tx_ovf_ev(tx_ovf && !flush), .rx_ovf_ev(rx_ovf && !flush),
        .rx_udf_ev(rx_udf && !flush), .cs_ev(cs_inactive),
        .raw(raw_irq), .msk(msk_irq), .irq(irq),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    p_thr_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en |=> ($stable(tx_thr_q) && $stable(rx_thr_q) && $stable(tx_dl_q) && $stable(rx_dl_q)));
    p_run_to_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !ctl_en) |=> (state == ST_FLUSH));
    p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> (tx_level == '0 && rx_level == '0));
    p_status_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[1] && status[2]) && !(status[3] && status[4]));
endmodule

// File: tb/spi_fifo_event_unit_test.sv
`timescale 1ns/1ps
module spi_fifo_event_unit_test;
    localparam int D = 8, W = 8, AW = 3, LW = 4;

    logic clk = 0, rst_n = 0, ctl_en = 0, eng_busy = 0, eng_slv_tx_busy = 0;
    logic sw_tx_push = 0, sw_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
    logic [W-1:0] sw_tx_data = 0, eng_rx_data = 0, sw_rx_data, eng_tx_data;
    logic thr_wr = 0;
    logic [AW-1:0] tx_irq_thr = 0, rx_irq_thr = 0, tx_dma_lvl = 0, rx_dma_lvl = 0;
    logic [1:0] dma_en = 0;
    logic [6:0] irq_mask = 0, raw_irq, msk_irq;
    logic clr_wr = 0, cs_inactive = 0, irq, dma_tx_req, dma_rx_req;
    logic [3:0] clr_word = 0;
    logic [LW-1:0] tx_level, rx_level;
    logic [5:0] status;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    spi_fifo_event_unit #(.DEPTH(D), .WIDTH(W)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic set_thr(input int ti, input int ri, input int td, input int rd);
        tx_irq_thr = AW'(ti); rx_irq_thr = AW'(ri); tx_dma_lvl = AW'(td); rx_dma_lvl = AW'(rd);
        thr_wr = 1; step(); thr_wr = 0;
    endtask

    task automatic tx_push(input int v);
        sw_tx_data = W'(v); sw_tx_push = 1; step(); sw_tx_push = 0;
    endtask

    task automatic rx_push(input int v);
        eng_rx_data = W'(v); eng_rx_push = 1; step(); eng_rx_push = 0;
    endtask

    task automatic do_clear(input logic [3:0] w);
        clr_word = w; clr_wr = 1; step(); clr_wr = 0; clr_word = 0;
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1; step();
        // R12 reset state
        chk("R12 tx_level", tx_level, 0);
        chk("R12 rx_level", rx_level, 0);
        chk("R12 raw", raw_irq, 7'b0000001);
        chk("R12 status", status, 6'b001100);
        chk("R12 irq", irq, 0);

        dma_en = 2'b11;
        for (int t = 0; t < D; t++) begin
            set_thr(t, t, t, t);
            for (int k = 0; k <= D; k++) begin
                chk("R4 tx low bit", raw_irq[0], (k <= t));
                chk("R9 dma tx", dma_tx_req, (k <= t));
                chk("R1 tx level", tx_level, k);
                if (k < D) tx_push(t * 16 + k);
            end
            chk("R8 tx full", status[2:1], 2'b01);
            for (int k = 0; k < D; k++) begin
                chk("R1 tx order", eng_tx_data, W'(t * 16 + k));
                eng_tx_pop = 1; step(); eng_tx_pop = 0;
            end
            for (int k = 0; k <= D; k++) begin
                chk("R4 rx high bit", raw_irq[4], (k >= t + 1));
                chk("R9 dma rx", dma_rx_req, (k > t));
                chk("R1 rx level", rx_level, k);
                chk("R4 bit5 zero", raw_irq[5], 0);
                if (k < D) rx_push(t * 16 + k + 1);
            end
            chk("R8 rx full", status[4:3], 2'b10);
            for (int k = 0; k < D; k++) begin
                chk("R1 rx order", sw_rx_data, W'(t * 16 + k + 1));
                sw_rx_pop = 1; step(); sw_rx_pop = 0;
            end
        end
        dma_en = 2'b00; #1;
        chk("R9 dma gated", {dma_tx_req, dma_rx_req}, 2'b00);

        // R2 overflow on both queues
        for (int k = 0; k < D; k++) tx_push(k + 32);
        tx_push(8'hEE);
        chk("R2 tx ovf flag", raw_irq[1], 1);
        chk("R2 tx level kept", tx_level, D);
        chk("R2 tx head kept", eng_tx_data, 32);
        for (int k = 0; k < D; k++) begin
            chk("R2 tx contents", eng_tx_data, W'(k + 32));
            eng_tx_pop = 1; step(); eng_tx_pop = 0;
        end
        for (int k = 0; k < D; k++) rx_push(k + 64);
        rx_push(8'hDD);
        chk("R2 rx ovf flag", raw_irq[3], 1);
        chk("R2 rx level kept", rx_level, D);
        for (int k = 0; k < D; k++) begin
            chk("R2 rx contents", sw_rx_data, W'(k + 64));
            sw_rx_pop = 1; step(); sw_rx_pop = 0;
        end
        // R3 underflow
        chk("R3 empty data zero", sw_rx_data, 0);
        chk("R3 no udf yet", raw_irq[2], 0);
        sw_rx_pop = 1; step(); sw_rx_pop = 0;
        chk("R3 udf flag", raw_irq[2], 1);
        chk("R3 level stays", rx_level, 0);

        // R5 individual clears
        do_clear(4'b0010);
        chk("R5 clr bit1", raw_irq[3:1], 3'b101);
        do_clear(4'b0100);
        chk("R5 clr bit2", raw_irq[3:1], 3'b001);
        do_clear(4'b1000);
        chk("R5 clr bit3", raw_irq[3:1], 3'b000);
        // R6 chip-select inactive
        cs_inactive = 1; step(); cs_inactive = 0;
        chk("R6 cs flag", raw_irq[6], 1);
        sw_rx_pop = 1; step(); sw_rx_pop = 0;
        rx_push(1); rx_push(2); // to check clear-all with ovf later: fill
        for (int k = 2; k < D; k++) rx_push(k);
        rx_push(9);
        for (int k = 0; k < D; k++) tx_push(k);
        tx_push(9);
        chk("R5 all set", {raw_irq[6], raw_irq[3:1]}, 4'b1111);
        do_clear(4'b0001);
        chk("R5 clr all", {raw_irq[6], raw_irq[3:1]}, 4'b0000);
        for (int k = 0; k < D; k++) begin
            sw_rx_pop = 1; eng_tx_pop = 1; step();
        end
        sw_rx_pop = 0; eng_tx_pop = 0;
        // R5 event wins over same-cycle clear
        sw_rx_pop = 1; clr_wr = 1; clr_word = 4'b0010; step();
        sw_rx_pop = 0; clr_wr = 0; clr_word = 0;
        chk("R5 set wins", raw_irq[2], 1);

        // R7 masks: raw = bit0 (tx empty, thr 7), bit2, bit6
        cs_inactive = 1; step(); cs_inactive = 0;
        chk("R7 raw base", raw_irq, 7'b1000101);
        for (int m = 0; m < 128; m++) begin
            irq_mask = 7'(m); #1;
            chk("R7 masked", msk_irq, 7'(m) & 7'b1000101);
            chk("R7 line", irq, |(7'(m) & 7'b1000101));
        end
        irq_mask = 0;

        // R8 engine status inputs
        for (int b = 0; b < 4; b++) begin
            eng_busy = b[0]; eng_slv_tx_busy = b[1]; #1;
            chk("R8 status", status, {b[1], 4'b0110, b[0]});
        end
        eng_busy = 0; eng_slv_tx_busy = 0;

        // R10 thresholds locked while enabled
        dma_en = 2'b10;
        ctl_en = 1; step();
        tx_push(1); tx_push(2); tx_push(3);
        chk("R10 bit0 before", raw_irq[0], 1);
        set_thr(0, 0, 0, 0);
        chk("R10 locked irq thr", raw_irq[0], 1);
        chk("R10 locked dma lvl", dma_tx_req, 1);
        rx_push(5); rx_push(6);

        // R11 flush on enable drop, push during flush dropped
        ctl_en = 0; step();
        chk("R11 levels held in flush", {tx_level, rx_level}, {4'd3, 4'd2});
        tx_push(7);
        chk("R11 tx flushed", tx_level, 0);
        chk("R11 rx flushed", rx_level, 0);

        // R10 accepted while disabled
        tx_push(1); tx_push(2); tx_push(3);
        set_thr(0, 0, 0, 0);
        chk("R10 accepted irq thr", raw_irq[0], 0);
        chk("R10 accepted dma lvl", dma_tx_req, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule